// File: doc/BRIEF.md
# DRAM Strobe Cycle-Type Decoder

This block models the device side of an asynchronous-strobe DRAM. It over-samples the active-low row strobe, column strobe, write enable and output enable on a fast system clock. From the order in which the strobes change it works out which kind of memory cycle the controller is running, including the cases where only the order tells the cycles apart, such as column strobe before row strobe or write enable before or after the column strobe. It captures row and column addresses and keeps a small scaled-down byte array. It steps an internal refresh row counter. It also decides when the 8-bit read data is driven, keeping the data on the pins after the column strobe rises.

Every strobe, address and data input first passes through a synchronizer of `SYNC_STAGES` flops. The block then compares each strobe with its value one clock earlier. An edge on the pins therefore takes effect `SYNC_STAGES + 1` clocks later, and all effects of that edge show on the outputs from that point. The block has no back-pressure: the strobe order itself is the handshake, and the block accepts every cycle the controller runs. A bench can use the block as a checker, because it reports the class of the latest cycle, a page-access flag, a test-mode flag and a sticky timing-error flag.

Top module: `dstrb_decoder`

## Requirements
- R1: A row-strobe fall while the column strobe is high captures the row address. A later column-strobe fall while the row strobe is low captures the column address. With write enable high, that column-strobe fall reads the stored byte onto `dout` and sets `cyc_type` to 1 (read).
- R2: Write enable low at a column-strobe fall inside an open row writes `din` to the addressed byte and sets `cyc_type` to 2 (early write). `dout_en` stays low for the whole access.
- R3: After a read, `dout_en` stays high after the column strobe rises, as long as output enable is low. Output enable high drops `dout_en`, and output enable low raises it again while the read data is still held. A write-enable fall, or both row and column strobes high, discards the held data.
- R4: A row-strobe fall while the column strobe is already low, with no read access still holding the column strobe, is a CBR refresh: `cyc_type` becomes 6 and `ref_row` increments by one. `ref_row` changes at no other time except at a hidden refresh (R6) and at a test-mode entry (R8).
- R5: A row-strobe pulse with the column strobe high throughout sets `cyc_type` to 5 (row-only refresh). `ref_row` does not change, `dout_en` stays low, and the stored bytes do not change.
- R6: When the column strobe stays low from a read while the row strobe rises and falls again, the cycle is a hidden refresh: `cyc_type` becomes 7, `ref_row` increments, and `dout`/`dout_en` keep the read data.
- R7: A write-enable fall during a read access, with the column strobe still low, writes `din` to the accessed byte and turns the output off. `cyc_type` becomes 4 (read-modify-write) if data was being driven at that moment, and 3 (delayed write) if output enable was high.
- R8: A CBR sequence with write enable low at the row-strobe fall sets `cyc_type` to 8 and `test_mode` to 1, and increments `ref_row`. A later CBR with write enable high, or a row-only refresh, clears `test_mode`.
- R9: `page_acc` is 0 for the first column access after a row-strobe fall and 1 for every further column access in the same row-strobe low period.
- R10: A column-strobe fall fewer than `MIN_RCD` clocks after the row-strobe fall sets `timing_err`. So does a row-strobe fall fewer than `MIN_RP` clocks after the previous row-strobe rise. The flag stays set until reset.
- R11: After reset, `dout_en`, `cyc_type` (0, idle), `ref_row`, `test_mode`, `timing_err` and `page_acc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Over-sampling clock |
| rst_n | input | 1 | Active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Data output driven (high) or high impedance (low) |
| cyc_type | output | 4 | Class of the latest cycle (codes in R1–R8, 0 idle) |
| page_acc | output | 1 | Latest column access was not the first in its row period |
| ref_row | output | ROW_W | Internal refresh row counter |
| row_lat | output | ROW_W | Captured row address |
| col_lat | output | COL_W | Captured column address |
| test_mode | output | 1 | Test mode active |
| timing_err | output | 1 | Sticky strobe timing violation |

## Verification
The hardest case to reach from the pins is the hidden refresh. The row strobe must rise and fall again while the column strobe is held low from a read, and the bench must show that the read data stays on `dout` while the refresh counter moves. The directed stimulus builds this sequence step by step. It also drives a plain CBR burst, so the two readings of "column strobe low at row-strobe fall" are told apart by history alone. A seeded random phase then mixes page-mode reads and writes across random rows, columns and page lengths, and checks every read against a bench model of the array.

// File: rtl/dstrb_pkg.sv
package dstrb_pkg;
  typedef enum logic [3:0] {
    CY_IDLE     = 4'd0,
    CY_READ     = 4'd1,
    CY_EARLY_WR = 4'd2,
    CY_LATE_WR  = 4'd3,
    CY_RMW      = 4'd4,
    CY_ROW_REF  = 4'd5,
    CY_CBR      = 4'd6,
    CY_HIDDEN   = 4'd7,
    CY_TEST     = 4'd8
  } cyc_e;
endpackage

// File: rtl/dstrb_sync.sv
module dstrb_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_V;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) chain[i] <= chain[i-1];
      chain[0] <= d;
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dstrb_array.sv
module dstrb_array #(
  parameter int AW = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dstrb_ctrl.sv
module dstrb_ctrl
  import dstrb_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int DATA_W = 8,
  parameter int AR_B = 6,
  parameter int AC_B = 4,
  parameter int MIN_RCD = 2,
  parameter int MIN_RP = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_c,
  input  logic                 cas_c,
  input  logic                 we_c,
  input  logic                 oe_c,
  input  logic [ROW_W-1:0]     addr_c,
  input  logic [DATA_W-1:0]    rdata,
  output logic                 wr_en,
  output logic [AR_B+AC_B-1:0] arr_addr,
  output logic [DATA_W-1:0]    dout_q,
  output logic                 dvalid,
  output cyc_e                 cyc,
  output logic                 page,
  output logic [ROW_W-1:0]     ref_cnt,
  output logic [ROW_W-1:0]     row_q,
  output logic [COL_W-1:0]     col_q,
  output logic                 test_mode,
  output logic                 timing_err
);
  localparam int RCD_W = $clog2(MIN_RCD + 1);
  localparam int RP_W  = $clog2(MIN_RP + 1);
  localparam logic [RCD_W-1:0] RCD_LIM = RCD_W'(MIN_RCD);
  localparam logic [RP_W-1:0]  RP_LIM  = RP_W'(MIN_RP);

  logic ras_p, cas_p, we_p;
  logic ras_f, ras_r, cas_f, cas_r, we_f;
  logic row_open, first_done, held, acc_rd;
  logic [RCD_W-1:0] rcnt;
  logic [RP_W-1:0]  pcnt;
  logic col_access, late_write;

  assign ras_f = ras_p & ~ras_c;
  assign ras_r = ~ras_p & ras_c;
  assign cas_f = cas_p & ~cas_c;
  assign cas_r = ~cas_p & cas_c;
  assign we_f  = we_p & ~we_c;

  assign col_access = cas_f & ~ras_c & row_open;
  assign late_write = we_f & acc_rd & ~cas_c & ~ras_c;
  assign wr_en      = (col_access & ~we_c) | late_write;
  assign arr_addr   = col_access ? {row_q[AR_B-1:0], addr_c[AC_B-1:0]}
                                 : {row_q[AR_B-1:0], col_q[AC_B-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1; cas_p <= 1'b1; we_p <= 1'b1;
      row_open <= 1'b0; first_done <= 1'b0; held <= 1'b0; acc_rd <= 1'b0;
      rcnt <= '0; pcnt <= RP_LIM;
      dout_q <= '0; dvalid <= 1'b0; cyc <= CY_IDLE; page <= 1'b0;
      ref_cnt <= '0; row_q <= '0; col_q <= '0;
      test_mode <= 1'b0; timing_err <= 1'b0;
    end else begin
      ras_p <= ras_c; cas_p <= cas_c; we_p <= we_c;

      // precharge and row-to-column spacing counters
      if (ras_r) pcnt <= RP_W'(1);
      else if (ras_c && pcnt < RP_LIM) pcnt <= pcnt + 1'b1;
      if (!ras_c && !ras_f && rcnt < RCD_LIM) rcnt <= rcnt + 1'b1;
      if (ras_r) row_open <= 1'b0;

      if (we_f || (ras_c && cas_c)) dvalid <= 1'b0;
      if (cas_r) begin
        held   <= 1'b0;
        acc_rd <= 1'b0;
      end

      if (ras_f) begin
        rcnt       <= RCD_W'(1);
        first_done <= 1'b0;
        if (pcnt < RP_LIM) timing_err <= 1'b1;
        if (cas_c) begin
          row_q     <= addr_c;
          row_open  <= 1'b1;
          cyc       <= CY_ROW_REF;
          test_mode <= 1'b0;
        end else begin
          row_open <= 1'b0;
          acc_rd   <= 1'b0;
          ref_cnt  <= ref_cnt + 1'b1;
          if (held) cyc <= CY_HIDDEN;
          else if (!we_c) begin
            cyc       <= CY_TEST;
            test_mode <= 1'b1;
          end else begin
            cyc       <= CY_CBR;
            test_mode <= 1'b0;
          end
        end
      end

      if (col_access) begin
        col_q      <= addr_c[COL_W-1:0];
        first_done <= 1'b1;
        page       <= first_done;
        if (rcnt < RCD_LIM) timing_err <= 1'b1;
        if (!we_c) begin
          cyc    <= CY_EARLY_WR;
          acc_rd <= 1'b0;
          dvalid <= 1'b0;
        end else begin
          cyc    <= CY_READ;
          dout_q <= rdata;
          dvalid <= 1'b1;
          acc_rd <= 1'b1;
          held   <= 1'b1;
        end
      end

      if (late_write) begin
        cyc    <= (dvalid && !oe_c) ? CY_RMW : CY_LATE_WR;
        acc_rd <= 1'b0;
      end
    end
  end

  // R4: the refresh counter only ever steps by one
  a_r4_refresh_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_cnt) |-> ref_cnt == ROW_W'($past(ref_cnt) + 1'b1));

  // R10: a timing error never clears outside reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timing_err |=> timing_err);

  // R3: both strobes high drops any held read data
  a_r3_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_c && cas_c) |=> !dvalid);

  // R2: an early write never leaves data to drive
  a_r2_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CY_EARLY_WR) |-> !dvalid);

  // R8: test mode is only entered by the test-entry cycle
  a_r8_test_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> cyc == CY_TEST);
endmodule

// File: rtl/dstrb_decoder.sv
module dstrb_decoder
  import dstrb_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int DATA_W = 8,
  parameter int AR_B = 6,
  parameter int AC_B = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RCD = 2,
  parameter int MIN_RP = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [3:0]        cyc_type,
  output logic              page_acc,
  output logic [ROW_W-1:0]  ref_row,
  output logic [ROW_W-1:0]  row_lat,
  output logic [COL_W-1:0]  col_lat,
  output logic              test_mode,
  output logic              timing_err
);
  localparam int DW = ROW_W + DATA_W;
  localparam int AW = AR_B + AC_B;

  logic [3:0]        strb_s;
  logic [DW-1:0]     data_s;
  logic [ROW_W-1:0]  addr_c;
  logic [DATA_W-1:0] din_c;
  logic              wr_en, dvalid;
  logic [AW-1:0]     arr_addr;
  logic [DATA_W-1:0] rdata;
  cyc_e              cyc;

  dstrb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_V(4'hF)) u_sync_strb (
    .clk(clk), .rst_n(rst_n), .d({ras_n, cas_n, we_n, oe_n}), .q(strb_s));

  dstrb_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_V('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(data_s));

  assign {addr_c, din_c} = data_s;

  dstrb_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .AR_B(AR_B), .AC_B(AC_B),
    .MIN_RCD(MIN_RCD), .MIN_RP(MIN_RP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ras_c(strb_s[3]), .cas_c(strb_s[2]), .we_c(strb_s[1]), .oe_c(strb_s[0]),
    .addr_c(addr_c), .rdata(rdata),
    .wr_en(wr_en), .arr_addr(arr_addr), .dout_q(dout), .dvalid(dvalid),
    .cyc(cyc), .page(page_acc), .ref_cnt(ref_row), .row_q(row_lat),
    .col_q(col_lat), .test_mode(test_mode), .timing_err(timing_err));

  dstrb_array #(.AW(AW), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(wr_en), .addr(arr_addr), .wdata(din_c), .rdata(rdata));

  assign dout_en  = dvalid & ~strb_s[0];
  assign cyc_type = cyc;
endmodule

// File: tb/dstrb_decoder_tb_top.sv
module dstrb_decoder_tb_top;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int DATA_W = 8;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic dout_en, page_acc, test_mode, timing_err;
  logic [3:0] cyc_type;
  logic [ROW_W-1:0] ref_row, row_lat;
  logic [COL_W-1:0] col_lat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [1024];
  bit written [1024];

  always #5 clk = ~clk;

  dstrb_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .cyc_type(cyc_type), .page_acc(page_acc), .ref_row(ref_row),
    .row_lat(row_lat), .col_lat(col_lat), .test_mode(test_mode),
    .timing_err(timing_err));

  function automatic int idx(input logic [12:0] r, input logic [12:0] c);
    return {r[5:0], c[3:0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(W);
  endtask

  task automatic ras_low(input logic [12:0] r);
    addr = r; ras_n = 1'b0; tick(W);
  endtask

  task automatic ras_high();
    ras_n = 1'b1; tick(W);
  endtask

  task automatic col_write(input logic [12:0] c, input logic [7:0] d);
    addr = c; din = d; we_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(W);
    chk("R2 early write class", cyc_type, 2);
    chk("R2 output off", dout_en, 0);
    cas_n = 1'b1; we_n = 1'b1; tick(W);
  endtask

  task automatic col_read(input logic [12:0] c, input logic [7:0] exp);
    addr = c; cas_n = 1'b0; tick(W);
    chk("R1 read class", cyc_type, 1);
    chk("R1 read data", dout, exp);
    chk("R1 driven", dout_en, 1);
    cas_n = 1'b1; tick(W);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d1, d2;
    logic [12:0] r0, r1;
    int unsigned seed;
    seed = $urandom(32'd4242);
    do_reset();

    // R11 reset state
    chk("R11 dout_en", dout_en, 0);
    chk("R11 cyc", cyc_type, 0);
    chk("R11 ref_row", ref_row, 0);
    chk("R11 test_mode", test_mode, 0);
    chk("R11 timing_err", timing_err, 0);
    chk("R11 page_acc", page_acc, 0);

    // R1/R2/R9 directed page write then page read
    r0 = 13'h1A05;
    ras_low(r0);
    chk("R1 row latch", row_lat, r0);
    col_write(13'h003, 8'hA5); chk("R9 first access", page_acc, 0);
    col_write(13'h007, 8'h3C); chk("R9 page access", page_acc, 1);
    chk("R1 col latch", col_lat, 10'h007);
    ras_high();
    ras_low(r0);
    col_read(13'h003, 8'hA5); chk("R9 first read", page_acc, 0);
    col_read(13'h007, 8'h3C); chk("R9 page read", page_acc, 1);
    chk("R3 EDO hold after CAS", dout_en, 1);
    ras_high();
    chk("R3 off with both high", dout_en, 0);
    model[idx(r0, 3)] = 8'hA5; written[idx(r0, 3)] = 1;
    model[idx(r0, 7)] = 8'h3C; written[idx(r0, 7)] = 1;

    // R3 output enable and write-enable control of held data
    ras_low(r0);
    addr = 13'h003; cas_n = 1'b0; tick(W); cas_n = 1'b1; tick(W);
    chk("R3 EDO driven", dout_en, 1);
    oe_n = 1'b1; tick(W);
    chk("R3 OE high off", dout_en, 0);
    oe_n = 1'b0; tick(W);
    chk("R3 OE low on again", dout_en, 1);
    we_n = 1'b0; tick(W);
    chk("R3 WE fall off", dout_en, 0);
    we_n = 1'b1; ras_high();

    // R5 row-only refresh
    ras_low(13'h0005); ras_high();
    chk("R5 class", cyc_type, 5);
    chk("R5 counter kept", ref_row, 0);
    chk("R5 output off", dout_en, 0);
    ras_low(r0); col_read(13'h003, 8'hA5); ras_high();
    chk("R5 storage kept", dout, 8'hA5);

    // R4 CBR refresh burst
    cas_n = 1'b0; tick(W);
    ras_n = 1'b0; tick(W);
    chk("R4 CBR class", cyc_type, 6);
    chk("R4 counter step", ref_row, 1);
    ras_n = 1'b1; tick(W);
    ras_n = 1'b0; tick(W);
    chk("R4 burst CBR", cyc_type, 6);
    chk("R4 counter step 2", ref_row, 2);
    ras_n = 1'b1; cas_n = 1'b1; tick(W);

    // R6 hidden refresh
    ras_low(r0);
    addr = 13'h007; cas_n = 1'b0; tick(W);
    chk("R6 read before", dout, 8'h3C);
    ras_n = 1'b1; tick(W);
    chk("R6 held while RAS high", dout_en, 1);
    ras_n = 1'b0; tick(W);
    chk("R6 class", cyc_type, 7);
    chk("R6 counter step", ref_row, 3);
    chk("R6 data kept", dout, 8'h3C);
    chk("R6 still driven", dout_en, 1);
    cas_n = 1'b1; tick(W); ras_high();
    chk("R6 off at end", dout_en, 0);

    // R8 test mode entry and exit
    we_n = 1'b0; cas_n = 1'b0; tick(W);
    ras_n = 1'b0; tick(W);
    chk("R8 class", cyc_type, 8);
    chk("R8 flag", test_mode, 1);
    chk("R8 counter step", ref_row, 4);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(W);
    ras_low(13'h0009); ras_high();
    chk("R8 exit by row-only", test_mode, 0);
    chk("R8 counter after exit", ref_row, 4);

    // R7 read-modify-write
    r1 = 13'h0822;
    ras_low(r1);
    col_write(13'h00A, 8'h11);
    addr = 13'h00A; cas_n = 1'b0; tick(W);
    chk("R7 read before modify", dout, 8'h11);
    din = 8'h99; we_n = 1'b0; tick(W);
    chk("R7 RMW class", cyc_type, 4);
    chk("R7 output off", dout_en, 0);
    cas_n = 1'b1; we_n = 1'b1; tick(W);
    // R7 delayed write with output enable high
    oe_n = 1'b1;
    addr = 13'h00B; cas_n = 1'b0; tick(W);
    din = 8'h5E; we_n = 1'b0; tick(W);
    chk("R7 delayed write class", cyc_type, 3);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; tick(W);
    ras_high();
    ras_low(r1);
    col_read(13'h00A, 8'h99);
    col_read(13'h00B, 8'h5E);
    ras_high();
    model[idx(r1, 10)] = 8'h99; written[idx(r1, 10)] = 1;
    model[idx(r1, 11)] = 8'h5E; written[idx(r1, 11)] = 1;

    // R1/R2/R9 random page traffic against the bench model
    for (int it = 0; it < 40; it++) begin
      logic [12:0] rr;
      int np;
      rr = 13'($urandom);
      np = 1 + int'($urandom % 4);
      ras_low(rr);
      for (int k = 0; k < np; k++) begin
        logic [12:0] cc;
        int ix;
        cc = 13'($urandom % 1024);
        ix = idx(rr, cc);
        if (written[ix] && ($urandom % 2 == 0)) begin
          col_read(cc, model[ix]);
        end else begin
          d1 = 8'($urandom);
          col_write(cc, d1);
          model[ix] = d1; written[ix] = 1;
        end
        chk("R9 random page flag", page_acc, (k > 0) ? 1 : 0);
      end
      ras_high();
    end
    chk("R10 no error on legal traffic", timing_err, 0);

    // R10 column strobe too soon after row strobe
    ras_n = 1'b0; addr = 13'h0001; tick(1);
    cas_n = 1'b0; tick(W);
    chk("R10 RCD violation", timing_err, 1);
    cas_n = 1'b1; tick(W); ras_high(); tick(W);
    chk("R10 sticky", timing_err, 1);

    // R10 precharge too short
    do_reset();
    chk("R10 cleared by reset", timing_err, 0);
    ras_low(13'h0002);
    ras_n = 1'b1; tick(1);
    ras_n = 1'b0; tick(W);
    chk("R10 RP violation", timing_err, 1);
    ras_high();

    d2 = 8'h00;
    if (d2 != 0) $display("unreachable");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule